// File: doc/BRIEF.md
# Multicycle Control Sequencer with Trap and Interrupt Entry

This block is the main control sequencer of a small multicycle processor core. An instruction takes between three and five cycles. It starts with a fetch cycle and a decode cycle. Then it follows a path chosen by the opcode: word load, word store, register-register arithmetic, branch-if-equal or jump.

Every cycle, the sequencer drives the datapath's write enables and multiplexer selects from its current state. It also reads three inputs:
- the opcode held in the instruction register,
- the ALU overflow flag,
- a pending-interrupt request.

Two extra states send the program counter to a fixed handler vector. The trap state is entered for an opcode with no defined path, or for an arithmetic overflow. It has the ALU compute PC minus 4, so the saved exception PC points back at the faulting instruction. The interrupt state is entered only at an instruction boundary, and it saves the already-incremented PC. In both states the block supplies a cause code for the cause register's write port. It also raises a select that tells a trap apart from an interrupt.

Top module: `ctrl_fsm_exc`

## Requirements
- R1: While `rstN` is low, every strobe output and `causeCode` is 0. The first cycle after `rstN` rises is a fetch cycle.
- R2: Fetch cycle: `memRead`, `irWrite` and `pcWrite` are 1, `iorD`=0, `aluSrcA`=0, `aluSrcB`=2'b01 (constant 4), `aluOp`=2'b00 (add), `pcSource`=2'b00 (ALU result), and all other strobes are 0. The next cycle is a decode cycle.
- R3: Decode cycle: `aluSrcB`=2'b11 (shifted immediate) and every other strobe is 0. The opcode picks the next path as follows:
  - 6'h23 goes to load.
  - 6'h2B goes to store.
  - 6'h00 goes to register-register.
  - 6'h04 goes to branch.
  - 6'h02 goes to jump.
  - Any other value goes to the trap cycle.
- R4: Register-register path: an execute cycle with `aluSrcA`=1, `aluSrcB`=2'b00 and `aluOp`=2'b10 (function field). Without overflow, a writeback cycle follows with `regDst`=1, `regWrite`=1 and `memToReg`=0. With `aluOverflow` high in the execute cycle, the trap cycle follows instead and no register write occurs.
- R5: Load and store paths:
  - Both begin with an address cycle: `aluSrcA`=1, `aluSrcB`=2'b10 (immediate), `aluOp`=2'b00.
  - Load: a read cycle follows (`memRead`=1, `iorD`=1), then a writeback cycle (`regWrite`=1, `memToReg`=1, `regDst`=0).
  - Store: a write cycle follows (`memWrite`=1, `iorD`=1).
  - `aluOverflow` has no effect on these paths.
- R6: Branch cycle: `aluSrcA`=1, `aluSrcB`=2'b00, `aluOp`=2'b01 (subtract), `pcSource`=2'b01 (ALU output register), `pcWriteCond`=1 and `pcWrite`=0.
- R7: Jump cycle: `pcSource`=2'b10 (jump target) and `pcWrite`=1, with every other strobe 0.
- R8: Trap cycle:
  - `causeStatusWrite`, `epcWrite` and `pcWrite` are 1.
  - `aluSrcA`=0, `aluSrcB`=2'b01, `aluOp`=2'b01, so the ALU forms PC-4.
  - `intrOrExcp`=1 and `pcSource`=2'b11 (handler vector).
  - `causeCode` is 10 after an undefined opcode and 12 after an overflow.
- R9: Interrupt cycle: `causeStatusWrite`, `epcWrite` and `pcWrite` are 1, `intrOrExcp`=0, `pcSource`=2'b11, `causeCode`=0, and the ALU selects are all 0. In any cycle without `causeStatusWrite`, `causeCode` is 0.
- R10: The last cycle of an instruction is a load writeback, store, register writeback, branch or jump. After it, the sequencer enters the interrupt cycle if `irqPending` is high, and fetch otherwise. The trap and interrupt cycles always return to fetch, even when `irqPending` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| aluOverflow | input | 1 | ALU signed-overflow flag |
| irqPending | input | 1 | Interrupt request pending |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| iorD | output | 1 | Memory address select: 0 PC, 1 ALU output register |
| irWrite | output | 1 | Instruction register load |
| regDst | output | 1 | Destination register select: 1 rd, 0 rt |
| regWrite | output | 1 | Register file write |
| memToReg | output | 1 | Writeback source: 1 memory data, 0 ALU output |
| aluSrcA | output | 1 | ALU A select: 0 PC, 1 register A |
| aluSrcB | output | 2 | ALU B select: register B, 4, immediate, shifted immediate |
| aluOp | output | 2 | ALU operation: add, subtract, function field |
| pcSource | output | 2 | PC source: ALU, ALU output, jump target, handler vector |
| pcWrite | output | 1 | Unconditional PC write |
| pcWriteCond | output | 1 | PC write when the ALU zero flag is set |
| epcWrite | output | 1 | Exception PC write |
| causeStatusWrite | output | 1 | Cause and status register write |
| intrOrExcp | output | 1 | 1 trap, 0 interrupt: selects what is saved |
| causeCode | output | 5 | Exception code for the cause register |

## Verification
Each of the five instruction classes is issued with the interrupt request low and then high:
- Low request: shows that each opcode follows its own cycle path, ending straight in fetch.
- High request: shows that the interrupt cycle is inserted only at the instruction boundary.

Overflow is raised with a register-register opcode to tell the overflow trap (code 12) apart from the normal writeback, and with a load to show that the flag is ignored outside the execute cycle. Undefined opcodes are issued both with and without a pending interrupt, which separates the undefined-opcode trap (code 10) from the interrupt cycle and shows that a trap never chains into an interrupt.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;

  typedef enum logic [3:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_MEMRD  = 4'd3,
    ST_LDWB   = 4'd4,
    ST_MEMWR  = 4'd5,
    ST_EXEC   = 4'd6,
    ST_RWB    = 4'd7,
    ST_JUMP   = 4'd8,
    ST_BRANCH = 4'd9,
    ST_TRAP   = 4'd10,
    ST_IRQ    = 4'd11
  } ctrlState_e;

  localparam logic [1:0] SRCB_REG   = 2'b00;
  localparam logic [1:0] SRCB_FOUR  = 2'b01;
  localparam logic [1:0] SRCB_IMM   = 2'b10;
  localparam logic [1:0] SRCB_SHIMM = 2'b11;

  localparam logic [1:0] ALUOP_ADD   = 2'b00;
  localparam logic [1:0] ALUOP_SUB   = 2'b01;
  localparam logic [1:0] ALUOP_FUNCT = 2'b10;

  localparam logic [1:0] PCSRC_ALU    = 2'b00;
  localparam logic [1:0] PCSRC_ALUOUT = 2'b01;
  localparam logic [1:0] PCSRC_JUMP   = 2'b10;
  localparam logic [1:0] PCSRC_VECTOR = 2'b11;

  typedef struct packed {
    logic       memRead;
    logic       memWrite;
    logic       iorD;
    logic       irWrite;
    logic       regDst;
    logic       regWrite;
    logic       memToReg;
    logic       aluSrcA;
    logic [1:0] aluSrcB;
    logic [1:0] aluOp;
    logic [1:0] pcSource;
    logic       pcWrite;
    logic       pcWriteCond;
    logic       epcWrite;
    logic       causeStatusWrite;
    logic       intrOrExcp;
  } strobes_t;

endpackage

// File: rtl/ctrl_seq.sv
module ctrl_seq
  import ctrl_pkg::*;
#(
  parameter int OP_W = 6,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'h23,
  parameter logic [OP_W-1:0] OP_STORE = 6'h2B,
  parameter logic [OP_W-1:0] OP_RTYPE = 6'h00,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'h04,
  parameter logic [OP_W-1:0] OP_JUMP  = 6'h02
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opcode,
  input  logic            aluOverflow,
  input  logic            irqPending,
  output ctrlState_e      state,
  output logic            trapIsOvf
);

  ctrlState_e nextState;
  ctrlState_e boundaryNext;

  // Target at an instruction boundary: interrupt entry or fetch.
  assign boundaryNext = irqPending ? ST_IRQ : ST_FETCH;

  always_comb begin
    nextState = ST_FETCH;
    case (state)
      ST_FETCH:  nextState = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OP_LOAD || opcode == OP_STORE) nextState = ST_ADDR;
        else if (opcode == OP_RTYPE)                 nextState = ST_EXEC;
        else if (opcode == OP_BEQ)                   nextState = ST_BRANCH;
        else if (opcode == OP_JUMP)                  nextState = ST_JUMP;
        else                                         nextState = ST_TRAP;
      end
      ST_ADDR:   nextState = (opcode == OP_LOAD) ? ST_MEMRD : ST_MEMWR;
      ST_MEMRD:  nextState = ST_LDWB;
      ST_EXEC:   nextState = aluOverflow ? ST_TRAP : ST_RWB;
      ST_LDWB,
      ST_MEMWR,
      ST_RWB,
      ST_JUMP,
      ST_BRANCH: nextState = boundaryNext;
      ST_TRAP,
      ST_IRQ:    nextState = ST_FETCH;
      default:   nextState = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_FETCH;
    end else begin
      state <= nextState;
    end
  end

  // Remembers why the trap cycle was entered; cleared on every decode.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapIsOvf <= 1'b0;
    end else if (state == ST_EXEC && aluOverflow) begin
      trapIsOvf <= 1'b1;
    end else if (state == ST_DECODE) begin
      trapIsOvf <= 1'b0;
    end
  end

endmodule

// File: rtl/ctrl_decode.sv
module ctrl_decode
  import ctrl_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter logic [CODE_W-1:0] CODE_INT   = 5'd0,
  parameter logic [CODE_W-1:0] CODE_UNDEF = 5'd10,
  parameter logic [CODE_W-1:0] CODE_OVF   = 5'd12
) (
  input  ctrlState_e        state,
  input  logic              trapIsOvf,
  input  logic              enable,
  output strobes_t          strobes,
  output logic [CODE_W-1:0] causeCode
);

  strobes_t raw;
  logic [CODE_W-1:0] rawCode;

  always_comb begin
    raw     = '0;
    rawCode = '0;
    case (state)
      ST_FETCH: begin
        raw.memRead  = 1'b1;
        raw.irWrite  = 1'b1;
        raw.aluSrcB  = SRCB_FOUR;
        raw.aluOp    = ALUOP_ADD;
        raw.pcSource = PCSRC_ALU;
        raw.pcWrite  = 1'b1;
      end
      ST_DECODE: begin
        raw.aluSrcB = SRCB_SHIMM;
        raw.aluOp   = ALUOP_ADD;
      end
      ST_ADDR: begin
        raw.aluSrcA = 1'b1;
        raw.aluSrcB = SRCB_IMM;
        raw.aluOp   = ALUOP_ADD;
      end
      ST_MEMRD: begin
        raw.memRead = 1'b1;
        raw.iorD    = 1'b1;
      end
      ST_LDWB: begin
        raw.regWrite = 1'b1;
        raw.memToReg = 1'b1;
      end
      ST_MEMWR: begin
        raw.memWrite = 1'b1;
        raw.iorD     = 1'b1;
      end
      ST_EXEC: begin
        raw.aluSrcA = 1'b1;
        raw.aluSrcB = SRCB_REG;
        raw.aluOp   = ALUOP_FUNCT;
      end
      ST_RWB: begin
        raw.regDst   = 1'b1;
        raw.regWrite = 1'b1;
      end
      ST_JUMP: begin
        raw.pcSource = PCSRC_JUMP;
        raw.pcWrite  = 1'b1;
      end
      ST_BRANCH: begin
        raw.aluSrcA     = 1'b1;
        raw.aluSrcB     = SRCB_REG;
        raw.aluOp       = ALUOP_SUB;
        raw.pcSource    = PCSRC_ALUOUT;
        raw.pcWriteCond = 1'b1;
      end
      ST_TRAP: begin
        raw.aluSrcB          = SRCB_FOUR;
        raw.aluOp            = ALUOP_SUB;
        raw.pcSource         = PCSRC_VECTOR;
        raw.pcWrite          = 1'b1;
        raw.epcWrite         = 1'b1;
        raw.causeStatusWrite = 1'b1;
        raw.intrOrExcp       = 1'b1;
        rawCode              = trapIsOvf ? CODE_OVF : CODE_UNDEF;
      end
      ST_IRQ: begin
        raw.pcSource         = PCSRC_VECTOR;
        raw.pcWrite          = 1'b1;
        raw.epcWrite         = 1'b1;
        raw.causeStatusWrite = 1'b1;
        raw.intrOrExcp       = 1'b0;
        rawCode              = CODE_INT;
      end
      default: begin
        raw     = '0;
        rawCode = '0;
      end
    endcase
  end

  assign strobes   = enable ? raw : '0;
  assign causeCode = enable ? rawCode : '0;

endmodule

// File: rtl/ctrl_fsm_exc.sv
module ctrl_fsm_exc
  import ctrl_pkg::*;
#(
  parameter int OP_W   = 6,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   opcode,
  input  logic              aluOverflow,
  input  logic              irqPending,
  output logic              memRead,
  output logic              memWrite,
  output logic              iorD,
  output logic              irWrite,
  output logic              regDst,
  output logic              regWrite,
  output logic              memToReg,
  output logic              aluSrcA,
  output logic [1:0]        aluSrcB,
  output logic [1:0]        aluOp,
  output logic [1:0]        pcSource,
  output logic              pcWrite,
  output logic              pcWriteCond,
  output logic              epcWrite,
  output logic              causeStatusWrite,
  output logic              intrOrExcp,
  output logic [CODE_W-1:0] causeCode
);

  ctrlState_e state;
  logic       trapIsOvf;
  strobes_t   strobes;

  ctrl_seq #(.OP_W(OP_W)) u_seq (
    .clk         (clk),
    .rstN        (rstN),
    .opcode      (opcode),
    .aluOverflow (aluOverflow),
    .irqPending  (irqPending),
    .state       (state),
    .trapIsOvf   (trapIsOvf)
  );

  ctrl_decode #(.CODE_W(CODE_W)) u_dec (
    .state     (state),
    .trapIsOvf (trapIsOvf),
    .enable    (rstN),
    .strobes   (strobes),
    .causeCode (causeCode)
  );

  assign memRead          = strobes.memRead;
  assign memWrite         = strobes.memWrite;
  assign iorD             = strobes.iorD;
  assign irWrite          = strobes.irWrite;
  assign regDst           = strobes.regDst;
  assign regWrite         = strobes.regWrite;
  assign memToReg         = strobes.memToReg;
  assign aluSrcA          = strobes.aluSrcA;
  assign aluSrcB          = strobes.aluSrcB;
  assign aluOp            = strobes.aluOp;
  assign pcSource         = strobes.pcSource;
  assign pcWrite          = strobes.pcWrite;
  assign pcWriteCond      = strobes.pcWriteCond;
  assign epcWrite         = strobes.epcWrite;
  assign causeStatusWrite = strobes.causeStatusWrite;
  assign intrOrExcp       = strobes.intrOrExcp;

endmodule

// File: rtl/ctrl_fsm_exc_chk.sv
module ctrl_fsm_exc_chk (
  input logic       clk,
  input logic       rstN,
  input logic       aluOverflow,
  input logic       memRead,
  input logic       memWrite,
  input logic       iorD,
  input logic       irWrite,
  input logic       regWrite,
  input logic       aluSrcA,
  input logic [1:0] aluSrcB,
  input logic [1:0] aluOp,
  input logic [1:0] pcSource,
  input logic       pcWrite,
  input logic       pcWriteCond,
  input logic       epcWrite,
  input logic       causeStatusWrite,
  input logic       intrOrExcp,
  input logic [4:0] causeCode
);

  // R1
  always_comb begin
    if (rstN == 1'b0) begin
      reset_quiet_chk: assert (!memWrite && !regWrite && !pcWrite && !pcWriteCond
                               && !epcWrite && !causeStatusWrite && !irWrite
                               && causeCode == 5'd0);
    end
  end

  // R2
  fetch_then_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    irWrite |=> (aluSrcB == 2'b11 && !pcWrite && !irWrite && !memRead && !regWrite));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aluSrcA && aluSrcB == 2'b00 && aluOp == 2'b10 && aluOverflow)
      |=> (!regWrite && causeStatusWrite && intrOrExcp && causeCode == 5'd12));

  // R5
  store_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> (iorD && !memRead && !pcWrite));

  // R6
  branch_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcWriteCond |-> (pcSource == 2'b01 && aluOp == 2'b01 && !pcWrite));

  // R8
  trap_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (causeStatusWrite && intrOrExcp) |-> (epcWrite && pcWrite && pcSource == 2'b11
      && aluOp == 2'b01 && aluSrcB == 2'b01 && (causeCode == 5'd10 || causeCode == 5'd12)));

  // R9
  irq_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (causeStatusWrite && !intrOrExcp) |-> (epcWrite && pcWrite && pcSource == 2'b11
      && causeCode == 5'd0));

  // R9
  code_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !causeStatusWrite |-> (causeCode == 5'd0));

  // R10
  handler_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    causeStatusWrite |=> (irWrite && memRead && !iorD && !causeStatusWrite));

endmodule

bind ctrl_fsm_exc ctrl_fsm_exc_chk u_chk (.*);

// File: tb/sim_ctrl_fsm_exc.sv
`timescale 1ns/1ps
module sim_ctrl_fsm_exc;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic       aluOverflow = 1'b0;
  logic       irqPending = 1'b0;
  logic       memRead, memWrite, iorD, irWrite, regDst, regWrite, memToReg, aluSrcA;
  logic [1:0] aluSrcB, aluOp, pcSource;
  logic       pcWrite, pcWriteCond, epcWrite, causeStatusWrite, intrOrExcp;
  logic [4:0] causeCode;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int pushCnt = 0;
  logic [23:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  ctrl_fsm_exc u0 (
    .clk(clk), .rstN(rstN), .opcode(opcode), .aluOverflow(aluOverflow),
    .irqPending(irqPending), .memRead(memRead), .memWrite(memWrite), .iorD(iorD),
    .irWrite(irWrite), .regDst(regDst), .regWrite(regWrite), .memToReg(memToReg),
    .aluSrcA(aluSrcA), .aluSrcB(aluSrcB), .aluOp(aluOp), .pcSource(pcSource),
    .pcWrite(pcWrite), .pcWriteCond(pcWriteCond), .epcWrite(epcWrite),
    .causeStatusWrite(causeStatusWrite), .intrOrExcp(intrOrExcp), .causeCode(causeCode)
  );

  function automatic logic [23:0] actual();
    return {memRead, memWrite, iorD, irWrite, regDst, regWrite, memToReg, aluSrcA,
            aluSrcB, aluOp, pcSource, pcWrite, pcWriteCond, epcWrite,
            causeStatusWrite, intrOrExcp, causeCode};
  endfunction

  // Expected outputs per cycle kind, taken from the requirement text.
  function automatic logic [23:0] expFor(int kind, logic [4:0] code);
    logic mr = 0, mw = 0, iod = 0, irw = 0, rd = 0, rw = 0, m2r = 0, sa = 0;
    logic pw = 0, pwc = 0, ew = 0, csw = 0, ioe = 0;
    logic [1:0] sb = 0, op = 0, ps = 0;
    case (kind)
      0:  begin mr = 1; irw = 1; sb = 2'b01; pw = 1; end
      1:  sb = 2'b11;
      2:  begin sa = 1; sb = 2'b10; end
      3:  begin mr = 1; iod = 1; end
      4:  begin rw = 1; m2r = 1; end
      5:  begin mw = 1; iod = 1; end
      6:  begin sa = 1; op = 2'b10; end
      7:  begin rd = 1; rw = 1; end
      8:  begin ps = 2'b10; pw = 1; end
      9:  begin sa = 1; op = 2'b01; ps = 2'b01; pwc = 1; end
      10: begin sb = 2'b01; op = 2'b01; ps = 2'b11; pw = 1; ew = 1; csw = 1; ioe = 1; end
      11: begin ps = 2'b11; pw = 1; ew = 1; csw = 1; end
      default: ;
    endcase
    return {mr, mw, iod, irw, rd, rw, m2r, sa, sb, op, ps, pw, pwc, ew, csw, ioe, code};
  endfunction

  task automatic push(input int kind, input logic [4:0] code, input string tag);
    expQ.push_back(expFor(kind, code));
    tagQ.push_back(tag);
    pushCnt++;
  endtask

  // Driver: called at a falling edge while the design sits in fetch.
  task automatic issue(input logic [5:0] op, input logic ovf, input logic irq);
    bit trapped = 0;
    pushCnt = 0;
    opcode = op;
    aluOverflow = ovf;
    irqPending = irq;
    push(0, 5'd0, "R2");
    push(1, 5'd0, "R3");
    case (op)
      6'h23: begin push(2, 5'd0, "R5"); push(3, 5'd0, "R5"); push(4, 5'd0, "R5"); end
      6'h2B: begin push(2, 5'd0, "R5"); push(5, 5'd0, "R5"); end
      6'h00: begin
        push(6, 5'd0, "R4");
        if (ovf) begin push(10, 5'd12, "R4,R8"); trapped = 1; end
        else push(7, 5'd0, "R4");
      end
      6'h04: push(9, 5'd0, "R6");
      6'h02: push(8, 5'd0, "R7");
      default: begin push(10, 5'd10, "R3,R8"); trapped = 1; end
    endcase
    if (irq && !trapped) push(11, 5'd0, "R9,R10");
    repeat (pushCnt) @(negedge clk);
  endtask

  // Monitor: compares one expected item per cycle, after the falling edge.
  always @(negedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      logic [23:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      total++;
      if (actual() !== e) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h at %0t", t, actual(), e, $time);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    total++;
    // R1: everything quiet during reset
    if (actual() !== 24'h0) begin
      bad++;
      $display("FAIL R1 actual=%h expected=%h", actual(), 24'h0);
    end
    @(negedge clk);
    rstN = 1'b1;
    // R1: first cycle after release is fetch (first pushed item)
    issue(6'h00, 1'b0, 1'b0);
    issue(6'h23, 1'b0, 1'b0);
    issue(6'h2B, 1'b0, 1'b0);
    issue(6'h04, 1'b0, 1'b0);
    issue(6'h02, 1'b0, 1'b0);
    issue(6'h00, 1'b1, 1'b0);   // R4 overflow trap, code 12
    issue(6'h3F, 1'b0, 1'b0);   // R3 undefined opcode, code 10
    issue(6'h08, 1'b0, 1'b0);   // R3 another undefined opcode
    issue(6'h23, 1'b1, 1'b0);   // R5 overflow ignored on load
    issue(6'h2B, 1'b1, 1'b0);   // R5 overflow ignored on store
    issue(6'h00, 1'b0, 1'b1);   // R10 interrupt after register writeback
    issue(6'h23, 1'b0, 1'b1);
    issue(6'h2B, 1'b0, 1'b1);
    issue(6'h04, 1'b0, 1'b1);
    issue(6'h02, 1'b0, 1'b1);
    issue(6'h3F, 1'b0, 1'b1);   // R10 trap does not chain into interrupt
    issue(6'h00, 1'b1, 1'b1);   // R10 overflow trap with interrupt pending
    issue(6'h00, 1'b0, 1'b0);   // back to normal after handler entries
    issue(6'h23, 1'b0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule